// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank With Wakeup

This block is a bank of up to 32 general-purpose lines behind a 32-bit register interface. Each line can be an input or an output. Input lines feed an event detector that can watch for rising edges, falling edges, high levels and low levels, in any mix per line. Every event sets the line's bit in two parallel interrupt status registers. Each status register has its own enable register and drives its own interrupt output, so two processors can each take a private view of the same events.

Level-sensitive conditions are evaluated on every cycle. A status bit whose level condition still holds therefore sets again as soon as software clears it. Output data, both interrupt enables and the wakeup enable each have a set alias and a clear alias, so single bits can change without a read-modify-write. A wakeup request output latches when an event hits a wake-enabled line while the system configuration allows wakeup and selects a non-zero idle mode. Any write to the system configuration register clears the request. The same register also carries a soft reset. The debounce registers hold their values and do nothing else.

Software writes with `bus_wr` high for one cycle, and the register updates at that clock edge. Reads are combinational from `bus_addr`.

Top module: `gpio_dual_irq_bank`

## Requirements
- R1: Register offsets (byte addresses on `bus_addr`):
  - 0x00 identity, which reads the parameter `REV_ID`.
  - 0x10 system config, 0x14 system status, 0x30 control.
  - 0x18 status A, 0x28 status B.
  - 0x1C enable A, 0x2C enable B, 0x20 wake enable.
  - 0x34 direction, 0x38 input data, 0x3C output data.
  - 0x40 low-level detect, 0x44 high-level detect, 0x48 rising detect, 0x4C falling detect.
  - 0x50 debounce enable, 0x54 debounce time.
  - Per-line registers read zero-extended to 32 bits. Unmapped offsets read 0.
- R2: Each alias pair is clear then set: 0x60/0x64 for enable A, 0x70/0x74 for enable B, 0x80/0x84 for wake enable, 0x90/0x94 for output data. A clear alias clears the bits written as 1 and a set alias sets them; other bits are unchanged. Reading an alias returns its underlying register.
- R3: A direction bit of 1 makes the line an input. Output lines never raise status. Changing direction re-evaluates the level conditions.
- R4: An event on a line sets that bit in both status registers. `irq_o[0]` is the OR of (status A AND enable A), and `irq_o[1]` is the same for bank B.
- R5: Writing a status register clears the bits written as 1. A bit whose level condition still holds stays set.
- R6: Rising, falling, high-level and low-level detection work per line, in any combination. A change on `gpio_i` reaches status two clock edges later.
- R7: System config:
  - A write with bit 1 set soft-resets every bank register.
  - The stored value is the written value AND 0x1D.
  - System status always reads 1.
- R8: Reset values:
  - Control stores 3 bits and resets to 2.
  - Direction resets to all ones.
  - Detect, enable, status, wake-enable, output data and debounce registers reset to zero.
  - Writes to input data, identity and system status are ignored.
- R9: `wake_req` sets when an event hits a line whose wake-enable bit is set, while system config bit 2 is 1 and bits 4:3 are non-zero. It stays set until any system config write.
- R10: Debounce enable stores one bit per line and debounce time stores 8 bits. Both are stored and read back only.
- R11: `gpio_o` shows the output data register and `gpio_dir_in` shows the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| gpio_i | input | N | Line input levels |
| gpio_o | output | N | Line output data |
| gpio_dir_in | output | N | Per-line direction, 1 = input |
| irq_o | output | 2 | Interrupt outputs for banks A and B |
| wake_req | output | 1 | Sticky wakeup request |

## Verification
The bench builds the bank with N = 8 and REV_ID = 0x3C. Eight lines make the zero-extension of every per-line register visible, along with the truncation of over-wide writes. The non-default identity shows that the parameter reaches the read path. Eight lines are still enough to give edge, level, output-line, wakeup and alias cases their own lines within one run. Each interrupt and wake outcome is compared against values derived from the requirements, at a fixed two-edge latency after each pin change.

// File: rtl/gdib_pkg.sv
package gdib_pkg;
   localparam int NUM_BANKS = 2;

   typedef enum logic [1:0] {OP_HOLD, OP_LOAD, OP_SET, OP_CLR} reg_op_e;

   localparam logic [7:0] A_ID       = 8'h00;
   localparam logic [7:0] A_SYSCFG   = 8'h10;
   localparam logic [7:0] A_SYSSTAT  = 8'h14;
   localparam logic [7:0] A_WAKEN    = 8'h20;
   localparam logic [7:0] A_CTRL     = 8'h30;
   localparam logic [7:0] A_DIR      = 8'h34;
   localparam logic [7:0] A_DIN      = 8'h38;
   localparam logic [7:0] A_DOUT     = 8'h3C;
   localparam logic [7:0] A_LVLO     = 8'h40;
   localparam logic [7:0] A_LVHI     = 8'h44;
   localparam logic [7:0] A_RISE     = 8'h48;
   localparam logic [7:0] A_FALL     = 8'h4C;
   localparam logic [7:0] A_DBEN     = 8'h50;
   localparam logic [7:0] A_DBTM     = 8'h54;
   localparam logic [7:0] A_WAKEN_C  = 8'h80;
   localparam logic [7:0] A_WAKEN_S  = 8'h84;
   localparam logic [7:0] A_DOUT_C   = 8'h90;
   localparam logic [7:0] A_DOUT_S   = 8'h94;

   // per-bank offsets, index 0 = bank A, 1 = bank B
   localparam logic [NUM_BANKS-1:0][7:0] A_STAT_V  = {8'h28, 8'h18};
   localparam logic [NUM_BANKS-1:0][7:0] A_EN_V    = {8'h2C, 8'h1C};
   localparam logic [NUM_BANKS-1:0][7:0] A_EN_C_V  = {8'h70, 8'h60};
   localparam logic [NUM_BANKS-1:0][7:0] A_EN_S_V  = {8'h74, 8'h64};

   localparam logic [4:0] SYSCFG_KEEP = 5'b11101;
   localparam int SC_SOFTRST = 1;
   localparam int SC_WAKE_EN = 2;

   function automatic reg_op_e op_decode(input logic wr, input logic [7:0] addr,
                                         input logic [7:0] a_ld, input logic [7:0] a_set,
                                         input logic [7:0] a_clr);
      if (!wr)                return OP_HOLD;
      else if (addr == a_ld)  return OP_LOAD;
      else if (addr == a_set) return OP_SET;
      else if (addr == a_clr) return OP_CLR;
      else                    return OP_HOLD;
   endfunction
endpackage

// File: rtl/gdib_opreg.sv
module gdib_opreg import gdib_pkg::*; #(
   parameter int W = 32,
   parameter logic [W-1:0] RSTV = '0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_rst,
   input  reg_op_e      op,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= RSTV;
      else if (soft_rst) q <= RSTV;
      else begin
         case (op)
            OP_LOAD: q <= d;
            OP_SET:  q <= q | d;
            OP_CLR:  q <= q & ~d;
            default: q <= q;
         endcase
      end
   end
endmodule

// File: rtl/gdib_detect.sv
module gdib_detect #(
   parameter int N = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_in,
   input  logic [N-1:0] dir_in,
   input  logic [N-1:0] lvlo,
   input  logic [N-1:0] lvhi,
   input  logic [N-1:0] rise,
   input  logic [N-1:0] fall,
   output logic [N-1:0] din,
   output logic [N-1:0] ev
);
   logic [N-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         din  <= '0;
         prev <= '0;
      end else begin
         din  <= pin_in;
         prev <= din;
      end
   end

   // levels are evaluated every cycle, so a cleared bit re-sets at once
   always_comb begin
      ev = ( (din & ~prev & rise) | (~din & prev & fall)
           | (din & lvhi)         | (~din & lvlo) ) & dir_in;
   end
endmodule

// File: rtl/gdib_status_bank.sv
module gdib_status_bank import gdib_pkg::*; #(
   parameter int N = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_rst,
   input  logic [N-1:0] ev,
   input  logic         clr_wr,
   input  reg_op_e      en_op,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] status,
   output logic [N-1:0] enable,
   output logic         irq
);
   gdib_opreg #(.W(N), .RSTV('0)) u_en (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .op(en_op), .d(wdata), .q(enable)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        status <= '0;
      else if (soft_rst) status <= '0;
      else               status <= (clr_wr ? (status & ~wdata) : status) | ev;
   end

   assign irq = |(status & enable);

   AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && (|ev)) |=> ((status & $past(ev)) == $past(ev))); // R4
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !soft_rst && ((wdata & ev) == '0)) |=> ((status & $past(wdata)) == '0)); // R5
endmodule

// File: rtl/gdib_regfile.sv
module gdib_regfile import gdib_pkg::*; #(
   parameter int N = 32,
   parameter logic [7:0] REV_ID = 8'h25
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic [7:0]                  bus_addr,
   input  logic [31:0]                 bus_wdata,
   input  logic [N-1:0]                din,
   input  logic [NUM_BANKS-1:0][N-1:0] stat,
   input  logic [NUM_BANKS-1:0][N-1:0] en,
   output logic                        soft_rst,
   output logic                        cfg_wr,
   output logic [4:0]                  sysconfig,
   output reg_op_e                     en_op [NUM_BANKS],
   output logic [NUM_BANKS-1:0]        clr_wr,
   output logic [N-1:0]                dir,
   output logic [N-1:0]                dout,
   output logic [N-1:0]                lvlo,
   output logic [N-1:0]                lvhi,
   output logic [N-1:0]                rise,
   output logic [N-1:0]                fall,
   output logic [N-1:0]                waken,
   output logic [31:0]                 bus_rdata
);
   logic [2:0]   ctrl;
   logic [N-1:0] dben;
   logic [7:0]   dbtm;

   assign cfg_wr   = bus_wr && (bus_addr == A_SYSCFG);
   assign soft_rst = cfg_wr && bus_wdata[SC_SOFTRST];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_dec
      assign en_op[b]  = op_decode(bus_wr, bus_addr, A_EN_V[b], A_EN_S_V[b], A_EN_C_V[b]);
      assign clr_wr[b] = bus_wr && (bus_addr == A_STAT_V[b]);
   end

   gdib_opreg #(.W(N), .RSTV('0)) u_dout (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .op(op_decode(bus_wr, bus_addr, A_DOUT, A_DOUT_S, A_DOUT_C)),
      .d(bus_wdata[N-1:0]), .q(dout)
   );
   gdib_opreg #(.W(N), .RSTV('0)) u_waken (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .op(op_decode(bus_wr, bus_addr, A_WAKEN, A_WAKEN_S, A_WAKEN_C)),
      .d(bus_wdata[N-1:0]), .q(waken)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sysconfig <= '0;  ctrl <= 3'd2;  dir  <= '1;
         lvlo <= '0; lvhi <= '0; rise <= '0; fall <= '0;
         dben <= '0; dbtm <= '0;
      end else if (soft_rst) begin
         sysconfig <= bus_wdata[4:0] & SYSCFG_KEEP;
         ctrl <= 3'd2;  dir  <= '1;
         lvlo <= '0; lvhi <= '0; rise <= '0; fall <= '0;
         dben <= '0; dbtm <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            A_SYSCFG: sysconfig <= bus_wdata[4:0] & SYSCFG_KEEP;
            A_CTRL:   ctrl      <= bus_wdata[2:0];
            A_DIR:    dir       <= bus_wdata[N-1:0];
            A_LVLO:   lvlo      <= bus_wdata[N-1:0];
            A_LVHI:   lvhi      <= bus_wdata[N-1:0];
            A_RISE:   rise      <= bus_wdata[N-1:0];
            A_FALL:   fall      <= bus_wdata[N-1:0];
            A_DBEN:   dben      <= bus_wdata[N-1:0];
            A_DBTM:   dbtm      <= bus_wdata[7:0];
            default:  ;
         endcase
      end
   end

   function automatic logic [31:0] zx(input logic [N-1:0] v);
      logic [31:0] r;
      r = '0;
      r[N-1:0] = v;
      return r;
   endfunction

   always_comb begin
      case (bus_addr)
         A_ID:                          bus_rdata = {24'h0, REV_ID};
         A_SYSCFG:                      bus_rdata = {27'h0, sysconfig};
         A_SYSSTAT:                     bus_rdata = 32'h1;
         A_STAT_V[0]:                   bus_rdata = zx(stat[0]);
         A_STAT_V[1]:                   bus_rdata = zx(stat[1]);
         A_EN_V[0], A_EN_C_V[0], A_EN_S_V[0]: bus_rdata = zx(en[0]);
         A_EN_V[1], A_EN_C_V[1], A_EN_S_V[1]: bus_rdata = zx(en[1]);
         A_WAKEN, A_WAKEN_C, A_WAKEN_S: bus_rdata = zx(waken);
         A_CTRL:                        bus_rdata = {29'h0, ctrl};
         A_DIR:                         bus_rdata = zx(dir);
         A_DIN:                         bus_rdata = zx(din);
         A_DOUT, A_DOUT_C, A_DOUT_S:    bus_rdata = zx(dout);
         A_LVLO:                        bus_rdata = zx(lvlo);
         A_LVHI:                        bus_rdata = zx(lvhi);
         A_RISE:                        bus_rdata = zx(rise);
         A_FALL:                        bus_rdata = zx(fall);
         A_DBEN:                        bus_rdata = zx(dben);
         A_DBTM:                        bus_rdata = {24'h0, dbtm};
         default:                       bus_rdata = '0;
      endcase
   end

   AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (dir == '1 && ctrl == 3'd2 && rise == '0 && waken == '0)); // R7
endmodule

// File: rtl/gpio_dual_irq_bank.sv
module gpio_dual_irq_bank import gdib_pkg::*; #(
   parameter int N = 32,
   parameter logic [7:0] REV_ID = 8'h25
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [7:0]           bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [N-1:0]         gpio_i,
   output logic [N-1:0]         gpio_o,
   output logic [N-1:0]         gpio_dir_in,
   output logic [NUM_BANKS-1:0] irq_o,
   output logic                 wake_req
);
   initial begin
      assert (N >= 1 && N <= 32) else $error("gpio_dual_irq_bank: N must be 1..32");
   end

   logic                        soft_rst, cfg_wr;
   logic [4:0]                  sysconfig;
   reg_op_e                     en_op [NUM_BANKS];
   logic [NUM_BANKS-1:0]        clr_wr;
   logic [N-1:0]                dir, dout, lvlo, lvhi, rise, fall, waken, din, ev;
   logic [NUM_BANKS-1:0][N-1:0] stat, en;
   logic                        wake_hit;

   gdib_regfile #(.N(N), .REV_ID(REV_ID)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .din(din), .stat(stat), .en(en),
      .soft_rst(soft_rst), .cfg_wr(cfg_wr), .sysconfig(sysconfig),
      .en_op(en_op), .clr_wr(clr_wr), .dir(dir), .dout(dout),
      .lvlo(lvlo), .lvhi(lvhi), .rise(rise), .fall(fall),
      .waken(waken), .bus_rdata(bus_rdata)
   );

   gdib_detect #(.N(N)) u_det (
      .clk(clk), .rst_n(rst_n), .pin_in(gpio_i), .dir_in(dir),
      .lvlo(lvlo), .lvhi(lvhi), .rise(rise), .fall(fall),
      .din(din), .ev(ev)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      gdib_status_bank #(.N(N)) u_bank (
         .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ev(ev),
         .clr_wr(clr_wr[b]), .en_op(en_op[b]), .wdata(bus_wdata[N-1:0]),
         .status(stat[b]), .enable(en[b]), .irq(irq_o[b])
      );
   end

   assign wake_hit = (|(ev & waken)) && sysconfig[SC_WAKE_EN] && (sysconfig[4:3] != 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_req <= 1'b0;
      else        wake_req <= (wake_req && !cfg_wr) || wake_hit;
   end

   assign gpio_o      = dout;
   assign gpio_dir_in = dir;

   AST_OUTPUT_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat[0] & ~$past(stat[0]) & ~$past(dir)) == '0)); // R3
   AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req && !cfg_wr) |=> wake_req); // R9
   AST_WAKE_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req) |-> ($past(sysconfig[SC_WAKE_EN]) && ($past(sysconfig[4:3]) != 2'b00))); // R9
endmodule

// File: tb/gpio_dual_irq_bank_test.sv
`timescale 1ns/100ps
module gpio_dual_irq_bank_test;
   localparam int N = 8;
   localparam logic [7:0] REV = 8'h3C;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [N-1:0] gpio_i = '0;
   logic [N-1:0] gpio_o, gpio_dir_in;
   logic [1:0]   irq_o;
   logic         wake_req;

   always #2.5 clk = ~clk;

   gpio_dual_irq_bank #(.N(N), .REV_ID(REV)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_i(gpio_i),
      .gpio_o(gpio_o), .gpio_dir_in(gpio_dir_in), .irq_o(irq_o), .wake_req(wake_req)
   );

   // kind: 0 read data, 1 {wake_req, irq_o}, 2 gpio_o, 3 gpio_dir_in
   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   event  smp;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 0;

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_item(input int kind, input logic [7:0] a,
                              input logic [31:0] e, input string tag);
      item_t it;
      bus_addr = a;
      it.kind = kind; it.exp = e; it.tag = tag;
      sb.push_back(it);
      #0.5;
      ->smp;
      #0.5;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      expect_item(0, a, e, tag);
   endtask

   // monitor: pops expected items and compares against the design
   initial begin
      forever begin
         @smp;
         while (sb.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
               0:       act = bus_rdata;
               1:       act = {29'h0, wake_req, irq_o};
               2:       act = 32'(gpio_o);
               default: act = 32'(gpio_dir_in);
            endcase
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // reset state
      rd(8'h30, 32'h2,  "R8 control reset");
      rd(8'h34, 32'hFF, "R8 direction reset");
      rd(8'h14, 32'h1,  "R7 sysstatus");
      rd(8'h00, 32'h3C, "R1 identity");
      rd(8'h18, 32'h0,  "R8 status A reset");
      expect_item(1, 8'h00, 32'h0, "R8 outputs idle");

      // rising edge into both banks
      wr(8'h48, 32'h01);
      wr(8'h64, 32'h01);
      gpio_i = 8'h01; tick(3);
      rd(8'h18, 32'h01, "R4 status A rising");
      rd(8'h28, 32'h01, "R4 status B rising");
      expect_item(1, 8'h00, 32'h1, "R4 irq A only");

      // write-one-to-clear on bank A only
      wr(8'h18, 32'h01);
      rd(8'h18, 32'h00, "R5 status A cleared");
      rd(8'h28, 32'h01, "R5 status B untouched");
      expect_item(1, 8'h00, 32'h0, "R4 irq A drops");

      // falling edge on line 1
      wr(8'h4C, 32'h02);
      gpio_i = 8'h03; tick(3);
      gpio_i = 8'h01; tick(3);
      rd(8'h18, 32'h02, "R6 falling only");
      rd(8'h28, 32'h03, "R6 status B accumulates");
      wr(8'h2C, 32'h02);
      expect_item(1, 8'h00, 32'h2, "R4 irq B only");
      wr(8'h18, 32'hFF); wr(8'h28, 32'hFF);

      // high-level detect re-asserts after clear
      gpio_i = 8'h05; tick(3);
      rd(8'h18, 32'h00, "R6 no level before enable");
      wr(8'h44, 32'h04); tick(1);
      rd(8'h18, 32'h04, "R6 high level");
      wr(8'h18, 32'h04);
      rd(8'h18, 32'h04, "R5 level re-asserts");
      gpio_i = 8'h01; tick(3);
      wr(8'h18, 32'h04);
      rd(8'h18, 32'h00, "R5 clear after level gone");
      wr(8'h44, 32'h00); wr(8'h28, 32'hFF);

      // output lines do not detect; direction change re-evaluates
      wr(8'h34, 32'hF7);
      wr(8'h40, 32'h08); tick(2);
      rd(8'h18, 32'h00, "R3 output line quiet");
      expect_item(3, 8'h00, 32'hF7, "R11 direction pins");
      wr(8'h34, 32'hFF); tick(1);
      rd(8'h18, 32'h08, "R3 re-evaluated as input");
      wr(8'h40, 32'h00); wr(8'h18, 32'hFF); wr(8'h28, 32'hFF);
      rd(8'h28, 32'h00, "R5 bank B clean");

      // output data aliases
      wr(8'h3C, 32'h0F);
      wr(8'h94, 32'h30);
      wr(8'h90, 32'h03);
      rd(8'h90, 32'h3C, "R2 alias reads data out");
      rd(8'h3C, 32'h3C, "R2 data out set/clear");
      expect_item(2, 8'h00, 32'h3C, "R11 output pins");

      // enable aliases
      wr(8'h74, 32'h05);
      wr(8'h70, 32'h02);
      rd(8'h74, 32'h05, "R2 enable B set/clear");
      wr(8'h60, 32'h01);
      rd(8'h1C, 32'h00, "R2 enable A clear alias");

      // read-only and unmapped
      wr(8'h38, 32'hFF); wr(8'h00, 32'h00); wr(8'h14, 32'h00);
      rd(8'h38, 32'h01, "R8 data in read-only");
      rd(8'h00, 32'h3C, "R8 identity read-only");
      rd(8'h14, 32'h01, "R7 sysstatus after write");
      rd(8'h08, 32'h00, "R1 unmapped reads zero");

      // wakeup
      wr(8'h84, 32'h10); wr(8'h84, 32'h20); wr(8'h80, 32'h20);
      rd(8'h20, 32'h10, "R2 wake enable aliases");
      wr(8'h10, 32'h04);
      wr(8'h48, 32'h11);
      gpio_i = 8'h11; tick(3);
      expect_item(1, 8'h00, 32'h0, "R9 no wake with idle mode zero");
      wr(8'h10, 32'h0C);
      gpio_i = 8'h01; tick(2);
      gpio_i = 8'h11; tick(3);
      expect_item(1, 8'h00, 32'h4, "R9 wake requested");
      tick(4);
      expect_item(1, 8'h00, 32'h4, "R9 wake sticky");
      wr(8'h10, 32'hFD);
      expect_item(1, 8'h00, 32'h0, "R9 wake cleared by config write");
      rd(8'h10, 32'h1D, "R7 config mask");

      // debounce storage
      wr(8'h50, 32'h1A5);
      wr(8'h54, 32'h1FF);
      rd(8'h50, 32'hA5, "R10 debounce enable width");
      rd(8'h54, 32'hFF, "R10 debounce time width");

      // control width
      wr(8'h30, 32'hFD);
      rd(8'h30, 32'h5, "R8 control three bits");

      // soft reset
      wr(8'h10, 32'h06);
      rd(8'h10, 32'h04, "R7 config after soft reset");
      rd(8'h30, 32'h2,  "R7 control after soft reset");
      rd(8'h34, 32'hFF, "R7 direction after soft reset");
      rd(8'h48, 32'h00, "R7 rising after soft reset");
      rd(8'h2C, 32'h00, "R7 enable B after soft reset");
      rd(8'h28, 32'h00, "R7 status B after soft reset");
      rd(8'h3C, 32'h00, "R7 data out after soft reset");
      rd(8'h50, 32'h00, "R7 debounce after soft reset");

      tick(2);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule